// File: doc/BRIEF.md
# Power-Management Register File

This block is the register space behind a serial control-bus slave in a power-management companion device. It has 32 word locations of 16 bits each. An access port carries one register access per cycle from the bus front end: a valid strobe, a write flag, a 5-bit register index and a 16-bit write word. Read data comes back combinationally from the addressed location. Only a handful of locations hold state: an identity word, an interrupt controller with status and mask, an ADC channel selector with a per-channel result bank, a sample-control word, a calibration word, two control words, a key-status word and a watchdog trigger. Every other index reads as zero and ignores writes.

Two event sources feed the block. A power-key pulse arrives with a level that tells whether the key is down. A load port fills the ADC result bank, standing in for a converter. The block drives an interrupt line that is registered one cycle behind the status and mask state. It also drives a shutdown request that latches when the watchdog is armed and then written with zero.

Top module: `pmu_regfile`

## Requirements
- R1: Index 0x00 reads 0x0215, with bit 7 also set while the `variant_strap` input is high. Writes to index 0x00 leave its value unchanged.
- R2: A write to index 0x01 replaces the interrupt status with the old status XOR the written word. A read of 0x01 returns the status, which resets to 0x0000.
- R3: Mask index 0x02 resets to 0xFFFF and is fully read/write. A mask bit of 1 blocks that status bit. `irq` is high in the cycle after a clock edge at which (status AND NOT mask) was non-zero, and low otherwise.
- R4: A read of index 0x08 returns the selected channel number in bits [13:10] and that channel's 10-bit result in bits [9:0]. A channel number at or above `ADC_CH` returns a result of zero. The channel resets to 0.
- R5: A write to index 0x08 takes the new channel number from bits [13:10] of the written word and ignores the word's other bits. The same write sets interrupt status bit 8.
- R6: Sample-control index 0x09 resets to `SAMPLE_INIT`. A write to it clears each bit that is 1 in the written word and leaves the other bits as they were.
- R7: A write of 0x0000 to index 0x17, made while bit 1 of control index 0x0D is 1, raises `shutdown_req` at the next edge. It then stays high until reset. A write of a non-zero word to 0x17 has no effect, and neither does any write to 0x17 while that bit is 0.
- R8: A `key_event` pulse sets interrupt status bit 0. Key-status index 0x16 resets to 0x0020. On each pulse its bit 5 becomes the inverse of `key_pressed`. Writes to 0x16 are ignored.
- R9: Calibration index 0x06 resets to 0x0001. Control indexes 0x0D and 0x0E reset to 0x0000. All three are full 16-bit read/write.
- R10: Every index other than 0x00, 0x01, 0x02, 0x06, 0x08, 0x09, 0x0D, 0x0E and 0x16 reads as 0x0000. Writes to those indexes change no readable state and no output.
- R11: A cycle with `adc_load` high stores `adc_load_value` as the result of channel `adc_load_chan`. A load to a channel at or above `ADC_CH` is dropped.
- R12: When a write to 0x01 and an event that sets a status bit (key pulse or ADC write) fall in the same cycle, the event's bit ends up 1 whatever the XOR would have given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| variant_strap | input | 1 | Variant strap shown in identity bit 7 |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_reg | input | ADDR_W | Register index |
| acc_wdata | input | DATA_W | Write word |
| acc_rdata | output | DATA_W | Read word of the addressed register (combinational) |
| key_event | input | 1 | One-cycle power-key event pulse |
| key_pressed | input | 1 | Key state sampled with the pulse (1 = pressed) |
| adc_load | input | 1 | Result-bank load strobe |
| adc_load_chan | input | 4 | Channel to load |
| adc_load_value | input | ADC_W | Result value to load |
| irq | output | 1 | Registered interrupt request |
| shutdown_req | output | 1 | Latched shutdown request |

## Verification
The bench builds the block with `ADC_CH` = 12 and `SAMPLE_INIT` = 0xA5C3. With 12 channels, selector values 12 to 15 fall outside the result bank, so the zero-result path and the dropped loads can be reached with the 4-bit channel field. The non-zero sample seed makes the clear-on-one behaviour visible bit by bit. With these settings the bench can sweep all 32 indexes, all 16 status bits and all 16 channel numbers, and compute each expected word arithmetically.

// File: rtl/pmu_pkg.sv
// Package: register indexes and bit positions shared by the register file.
// Assumes a 5-bit index space; positions here are decoded by bus masters.
package pmu_pkg;
    localparam int REG_ID       = 'h00;
    localparam int REG_IRQ_STAT = 'h01;
    localparam int REG_IRQ_MASK = 'h02;
    localparam int REG_CAL      = 'h06;
    localparam int REG_ADC      = 'h08;
    localparam int REG_SAMPLE   = 'h09;
    localparam int REG_CTRL_A   = 'h0D;
    localparam int REG_CTRL_B   = 'h0E;
    localparam int REG_KEYSTAT  = 'h16;
    localparam int REG_WDOG     = 'h17;

    localparam logic [15:0] ID_BASE = 16'h0215;
    localparam int ID_VARIANT_BIT   = 7;
    localparam int IRQ_KEY_BIT      = 0;
    localparam int IRQ_ADC_BIT      = 8;
    localparam int KEYSTAT_BIT      = 5;
    localparam int WDOG_EN_BIT      = 1;
    localparam int ADC_CH_LSB       = 10;
    localparam int ADC_CH_W         = 4;
endpackage

// File: rtl/pmu_irq_ctrl.sv
// Interrupt controller: XOR-toggled status, mask (1 = blocked), registered irq.
// Assumes set events are single-cycle and take priority over a same-cycle XOR.
module pmu_irq_ctrl #(
    parameter int DATA_W  = 16,
    parameter int KEY_BIT = 0,
    parameter int ADC_BIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_wr,
    input  logic              mask_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              key_set,
    input  logic              adc_set,
    output logic [DATA_W-1:0] status_q,
    output logic [DATA_W-1:0] mask_q,
    output logic              irq
);
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] status_xor;

    // Collect event-driven set bits into one vector.
    always_comb begin
        set_vec          = '0;
        set_vec[KEY_BIT] = key_set;
        set_vec[ADC_BIT] = adc_set;
    end

    // Apply the software toggle before the event sets so events win.
    always_comb begin
        status_xor = stat_wr ? (status_q ^ wdata) : status_q;
    end

    // Status register update.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_xor | set_vec;
    end

    // Mask register update.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_wr) mask_q <= wdata;
    end

    // Registered interrupt output from the current unmasked status.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(status_q & ~mask_q);
    end

    a_r3_full_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&$past(mask_q)) |-> !irq);
    a_r12_key_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        key_set |=> status_q[KEY_BIT]);
    a_r5_adc_done_set: assert property (@(posedge clk) disable iff (!rst_n)
        adc_set |=> status_q[ADC_BIT]);
    a_r3_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(mask_q));
endmodule

// File: rtl/pmu_adc_bank.sv
// ADC channel selector, per-channel result bank and clear-on-one sample word.
// Assumes ADC_W does not exceed CH_LSB so channel and result fields do not overlap.
module pmu_adc_bank #(
    parameter int          DATA_W      = 16,
    parameter int          ADC_CH      = 16,
    parameter int          ADC_W       = 10,
    parameter int          CH_LSB      = 10,
    parameter int          CH_W        = 4,
    parameter logic [15:0] SAMPLE_INIT = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic              sample_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              load_en,
    input  logic [CH_W-1:0]   load_chan,
    input  logic [ADC_W-1:0]  load_val,
    output logic [DATA_W-1:0] adc_word,
    output logic [DATA_W-1:0] sample_q
);
    logic [CH_W-1:0]  chan_q;
    logic [ADC_W-1:0] result [ADC_CH];
    logic [ADC_W-1:0] picked;

    // Channel selector update from the write word's channel field.
    always_ff @(posedge clk) begin
        if (!rst_n)      chan_q <= '0;
        else if (sel_wr) chan_q <= wdata[CH_LSB +: CH_W];
    end

    // One result entry per channel, loaded only on a matching index.
    for (genvar g = 0; g < ADC_CH; g++) begin : g_result
        always_ff @(posedge clk) begin
            if (!rst_n)
                result[g] <= '0;
            else if (load_en && (int'(load_chan) == g))
                result[g] <= load_val;
        end
    end

    // Select the addressed result; indexes past the bank yield zero.
    always_comb begin
        picked = '0;
        for (int k = 0; k < ADC_CH; k++) begin
            if (int'(chan_q) == k) picked = result[k];
        end
    end

    // Assemble the read word: channel field above, result below.
    always_comb begin
        adc_word                     = '0;
        adc_word[CH_LSB +: CH_W]     = chan_q;
        adc_word[ADC_W-1:0]          = picked;
    end

    // Sample-control word: written ones clear bits.
    always_ff @(posedge clk) begin
        if (!rst_n)         sample_q <= SAMPLE_INIT[DATA_W-1:0];
        else if (sample_wr) sample_q <= sample_q & ~wdata;
    end

    a_r6_no_new_ones: assert property (@(posedge clk) disable iff (!rst_n)
        sample_wr |=> ((sample_q & ~$past(sample_q)) == '0));
    a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_wr |=> $stable(sample_q));
    a_r4_chan_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_wr |=> $stable(chan_q));
endmodule

// File: rtl/pmu_ctrl_regs.sv
// Calibration and control words, key-status bit and watchdog shutdown latch.
// Assumes the watchdog arm bit is sampled from the control word before the write.
module pmu_ctrl_regs #(
    parameter int          DATA_W      = 16,
    parameter logic [15:0] CAL_INIT    = 16'h0001,
    parameter int          KEY_BIT     = 5,
    parameter int          WDOG_EN_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_wr,
    input  logic              ctrla_wr,
    input  logic              ctrlb_wr,
    input  logic              wdog_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              key_event,
    input  logic              key_pressed,
    output logic [DATA_W-1:0] cal_q,
    output logic [DATA_W-1:0] ctrla_q,
    output logic [DATA_W-1:0] ctrlb_q,
    output logic [DATA_W-1:0] keystat_word,
    output logic              shutdown_req
);
    logic key_up_q;
    logic wdog_fire;

    // Calibration word storage.
    always_ff @(posedge clk) begin
        if (!rst_n)      cal_q <= CAL_INIT[DATA_W-1:0];
        else if (cal_wr) cal_q <= wdata;
    end

    // Control word A storage (holds the watchdog arm bit).
    always_ff @(posedge clk) begin
        if (!rst_n)        ctrla_q <= '0;
        else if (ctrla_wr) ctrla_q <= wdata;
    end

    // Control word B storage.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctrlb_q <= '0;
        else if (ctrlb_wr) ctrlb_q <= wdata;
    end

    // Key-up flag follows the key level captured with each event pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)         key_up_q <= 1'b1;
        else if (key_event) key_up_q <= !key_pressed;
    end

    // Expose the key-up flag at its bit position.
    always_comb begin
        keystat_word          = '0;
        keystat_word[KEY_BIT] = key_up_q;
    end

    // Decide whether this access trips the watchdog.
    always_comb begin
        wdog_fire = wdog_wr && (wdata == '0) && ctrla_q[WDOG_EN_BIT];
    end

    // Sticky shutdown request until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         shutdown_req <= 1'b0;
        else if (wdog_fire) shutdown_req <= 1'b1;
    end

    a_r7_shutdown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |=> shutdown_req);
    a_r7_shutdown_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown_req) |-> $past(wdog_wr && (wdata == '0) && ctrla_q[WDOG_EN_BIT]));
    a_r8_key_level: assert property (@(posedge clk) disable iff (!rst_n)
        key_event |=> (keystat_word[KEY_BIT] == !$past(key_pressed)));
    a_r9_cal_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_wr |=> $stable(cal_q));
endmodule

// File: rtl/pmu_regfile.sv
// Top: register decode and read mux for the power-management register file.
// Assumes one access per cycle from the bus front end; reads have no side effects.
module pmu_regfile #(
    parameter int          DATA_W      = 16,
    parameter int          ADDR_W      = 5,
    parameter int          ADC_CH      = 16,
    parameter int          ADC_W       = 10,
    parameter logic [15:0] SAMPLE_INIT = 16'h0000,
    parameter logic [15:0] CAL_INIT    = 16'h0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              variant_strap,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_reg,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic              key_event,
    input  logic              key_pressed,
    input  logic              adc_load,
    input  logic [3:0]        adc_load_chan,
    input  logic [ADC_W-1:0]  adc_load_value,
    output logic              irq,
    output logic              shutdown_req
);
    import pmu_pkg::*;

    localparam int CH_W = ADC_CH_W;

    logic wr;
    logic stat_wr, mask_wr, cal_wr, adc_wr, sample_wr;
    logic ctrla_wr, ctrlb_wr, wdog_wr;
    logic [DATA_W-1:0] status_q, mask_q, adc_word, sample_q;
    logic [DATA_W-1:0] cal_q, ctrla_q, ctrlb_q, keystat_word;
    logic [DATA_W-1:0] id_word;

    // Per-register write strobes.
    always_comb begin
        wr        = acc_valid && acc_write;
        stat_wr   = wr && (int'(acc_reg) == REG_IRQ_STAT);
        mask_wr   = wr && (int'(acc_reg) == REG_IRQ_MASK);
        cal_wr    = wr && (int'(acc_reg) == REG_CAL);
        adc_wr    = wr && (int'(acc_reg) == REG_ADC);
        sample_wr = wr && (int'(acc_reg) == REG_SAMPLE);
        ctrla_wr  = wr && (int'(acc_reg) == REG_CTRL_A);
        ctrlb_wr  = wr && (int'(acc_reg) == REG_CTRL_B);
        wdog_wr   = wr && (int'(acc_reg) == REG_WDOG);
    end

    // Identity word with the strap-controlled variant bit.
    always_comb begin
        id_word                 = ID_BASE[DATA_W-1:0];
        id_word[ID_VARIANT_BIT] = variant_strap;
    end

    pmu_irq_ctrl #(
        .DATA_W (DATA_W),
        .KEY_BIT(IRQ_KEY_BIT),
        .ADC_BIT(IRQ_ADC_BIT)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat_wr (stat_wr),
        .mask_wr (mask_wr),
        .wdata   (acc_wdata),
        .key_set (key_event),
        .adc_set (adc_wr),
        .status_q(status_q),
        .mask_q  (mask_q),
        .irq     (irq)
    );

    pmu_adc_bank #(
        .DATA_W     (DATA_W),
        .ADC_CH     (ADC_CH),
        .ADC_W      (ADC_W),
        .CH_LSB     (ADC_CH_LSB),
        .CH_W       (CH_W),
        .SAMPLE_INIT(SAMPLE_INIT)
    ) u_adc (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_wr   (adc_wr),
        .sample_wr(sample_wr),
        .wdata    (acc_wdata),
        .load_en  (adc_load),
        .load_chan(adc_load_chan),
        .load_val (adc_load_value),
        .adc_word (adc_word),
        .sample_q (sample_q)
    );

    pmu_ctrl_regs #(
        .DATA_W     (DATA_W),
        .CAL_INIT   (CAL_INIT),
        .KEY_BIT    (KEYSTAT_BIT),
        .WDOG_EN_BIT(WDOG_EN_BIT)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cal_wr      (cal_wr),
        .ctrla_wr    (ctrla_wr),
        .ctrlb_wr    (ctrlb_wr),
        .wdog_wr     (wdog_wr),
        .wdata       (acc_wdata),
        .key_event   (key_event),
        .key_pressed (key_pressed),
        .cal_q       (cal_q),
        .ctrla_q     (ctrla_q),
        .ctrlb_q     (ctrlb_q),
        .keystat_word(keystat_word),
        .shutdown_req(shutdown_req)
    );

    // Read multiplexer; unlisted indexes return zero.
    always_comb begin
        case (int'(acc_reg))
            REG_ID:       acc_rdata = id_word;
            REG_IRQ_STAT: acc_rdata = status_q;
            REG_IRQ_MASK: acc_rdata = mask_q;
            REG_CAL:      acc_rdata = cal_q;
            REG_ADC:      acc_rdata = adc_word;
            REG_SAMPLE:   acc_rdata = sample_q;
            REG_CTRL_A:   acc_rdata = ctrla_q;
            REG_CTRL_B:   acc_rdata = ctrlb_q;
            REG_KEYSTAT:  acc_rdata = keystat_word;
            default:      acc_rdata = '0;
        endcase
    end

    // R1: identity upper byte never moves.
    always_comb begin
        if (int'(acc_reg) == REG_ID)
            a_r1_id_upper: assert (acc_rdata[15:8] == 8'h02);
    end

    a_r10_wdog_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(acc_reg) == REG_WDOG) |-> (acc_rdata == '0));
endmodule

// File: tb/pmu_regfile_tb.sv
module pmu_regfile_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADC_CH     = 12;
    localparam logic [15:0] SEED = 16'hA5C3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        variant_strap = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [4:0]  acc_reg = '0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] acc_rdata;
    logic        key_event = 1'b0;
    logic        key_pressed = 1'b0;
    logic        adc_load = 1'b0;
    logic [3:0]  adc_load_chan = '0;
    logic [9:0]  adc_load_value = '0;
    logic        irq;
    logic        shutdown_req;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] rv;
    logic [15:0] exp_status;
    logic [15:0] exp_sample;

    pmu_regfile #(
        .ADC_CH     (ADC_CH),
        .SAMPLE_INIT(SEED)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .variant_strap (variant_strap),
        .acc_valid     (acc_valid),
        .acc_write     (acc_write),
        .acc_reg       (acc_reg),
        .acc_wdata     (acc_wdata),
        .acc_rdata     (acc_rdata),
        .key_event     (key_event),
        .key_pressed   (key_pressed),
        .adc_load      (adc_load),
        .adc_load_chan (adc_load_chan),
        .adc_load_value(adc_load_value),
        .irq           (irq),
        .shutdown_req  (shutdown_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input int r, input logic [15:0] v);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_reg = 5'(r); acc_wdata = v;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd(input int r, output logic [15:0] v);
        @(negedge clk);
        acc_reg = 5'(r);
        #1 v = acc_rdata;
    endtask

    task automatic key(input logic pressed);
        @(negedge clk);
        key_event = 1'b1; key_pressed = pressed;
        @(negedge clk);
        key_event = 1'b0;
    endtask

    function automatic logic [15:0] reset_val(input int r);
        case (r)
            'h00: return 16'h0215;
            'h02: return 16'hFFFF;
            'h06: return 16'h0001;
            'h09: return SEED;
            'h16: return 16'h0020;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [9:0] chan_val(input int ch);
        return 10'((ch * 37 + 5) & 'h3FF);
    endfunction

    function automatic bit is_impl(input int r);
        return (r == 'h00 || r == 'h01 || r == 'h02 || r == 'h06 || r == 'h08 ||
                r == 'h09 || r == 'h0D || r == 'h0E || r == 'h16);
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state sweep over all indexes (R1 R3 R6 R8 R9 R10)
        chk("R3 irq reset", {15'd0, irq}, 16'h0000);
        chk("R7 shutdown reset", {15'd0, shutdown_req}, 16'h0000);
        for (int r = 0; r < 32; r++) begin
            rd(r, rv);
            chk($sformatf("R10 reset idx %0h", r), rv, reset_val(r));
        end

        // R1: strap and read-only identity
        variant_strap = 1'b1;
        rd('h00, rv); chk("R1 strap high", rv, 16'h0295);
        do_write('h00, 16'hFFFF);
        rd('h00, rv); chk("R1 write ignored", rv, 16'h0295);
        variant_strap = 1'b0;
        rd('h00, rv); chk("R1 strap low", rv, 16'h0215);

        // R10: writes to unimplemented indexes change nothing
        for (int r = 0; r < 32; r++)
            if (!is_impl(r)) do_write(r, 16'hFFFF);
        for (int r = 0; r < 32; r++) begin
            rd(r, rv);
            chk($sformatf("R10 after stray writes idx %0h", r), rv, reset_val(r));
        end
        chk("R10 no shutdown", {15'd0, shutdown_req}, 16'h0000);
        chk("R10 no irq", {15'd0, irq}, 16'h0000);

        // R9: read/write words
        do_write('h06, 16'hBEEF); rd('h06, rv); chk("R9 cal", rv, 16'hBEEF);
        do_write('h0D, 16'h5A58); rd('h0D, rv); chk("R9 ctrl A", rv, 16'h5A58);
        do_write('h0E, 16'hFFFF); rd('h0E, rv); chk("R9 ctrl B", rv, 16'hFFFF);
        do_write('h0D, 16'h0000); rd('h0D, rv); chk("R9 ctrl A clear", rv, 16'h0000);

        // R2: XOR toggling per bit with full mask (R3 irq held low)
        exp_status = 16'h0000;
        for (int i = 0; i < 16; i++) begin
            do_write('h01, 16'(1 << i));
            exp_status ^= 16'(1 << i);
            rd('h01, rv);
            chk($sformatf("R2 toggle bit %0d", i), rv, exp_status);
        end
        chk("R3 masked irq low", {15'd0, irq}, 16'h0000);
        do_write('h01, 16'hA5A5); exp_status ^= 16'hA5A5;
        rd('h01, rv); chk("R2 pattern xor", rv, exp_status);

        // R3: mask readback and one-cycle irq latency
        do_write('h02, 16'h5A5A);
        rd('h02, rv); chk("R3 mask readback", rv, 16'h5A5A);
        do_write('h02, 16'hFFFF);
        do_write('h01, exp_status); exp_status = 16'h0000;
        do_write('h01, 16'h0040); exp_status = 16'h0040;
        do_write('h02, 16'hFFBF);
        chk("R3 irq not yet", {15'd0, irq}, 16'h0000);
        @(negedge clk);
        chk("R3 irq one cycle later", {15'd0, irq}, 16'h0001);
        do_write('h02, 16'h0040);
        @(negedge clk);
        chk("R3 irq masked off", {15'd0, irq}, 16'h0000);
        do_write('h01, 16'h0040); exp_status = 16'h0000;
        do_write('h02, 16'h0000);
        @(negedge clk);
        chk("R3 irq no status", {15'd0, irq}, 16'h0000);
        do_write('h02, 16'hFFFF);

        // R11: load the result bank, including channels past the bank
        for (int ch = 0; ch < 16; ch++) begin
            @(negedge clk);
            adc_load = 1'b1; adc_load_chan = 4'(ch); adc_load_value = chan_val(ch);
        end
        @(negedge clk);
        adc_load = 1'b0;

        // R4 R5 R11: channel select sweep and sample-done bit
        for (int ch = 0; ch < 16; ch++) begin
            do_write('h08, 16'((ch << 10) | 'hC3FF));
            rd('h08, rv);
            chk($sformatf("R4 R11 channel %0d", ch), rv,
                16'((ch << 10) | ((ch < ADC_CH) ? int'(chan_val(ch)) : 0)));
            rd('h01, rv);
            chk($sformatf("R5 done bit ch %0d", ch), rv, 16'h0100);
            do_write('h01, 16'h0100);
        end

        // R6: clear-on-one sample word
        exp_sample = SEED;
        do_write('h09, 16'h00C3); exp_sample &= ~16'h00C3;
        rd('h09, rv); chk("R6 clear low byte", rv, exp_sample);
        do_write('h09, 16'h0000);
        rd('h09, rv); chk("R6 zero write", rv, exp_sample);
        do_write('h09, 16'h8400); exp_sample &= ~16'h8400;
        rd('h09, rv); chk("R6 clear mixed", rv, exp_sample);

        // R8: key events
        key(1'b1);
        rd('h16, rv); chk("R8 pressed", rv, 16'h0000);
        rd('h01, rv); chk("R8 status bit0", rv, 16'h0001);
        do_write('h16, 16'hFFFF);
        rd('h16, rv); chk("R8 write ignored", rv, 16'h0000);
        key(1'b0);
        rd('h16, rv); chk("R8 released", rv, 16'h0020);

        // R12: XOR clear and key event in the same cycle
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_reg = 5'h01; acc_wdata = 16'h0001;
        key_event = 1'b1; key_pressed = 1'b0;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; key_event = 1'b0;
        rd('h01, rv); chk("R12 key wins", rv, 16'h0001);
        // R12: XOR of bit 8 with ADC write in same cycle is not possible on one port;
        // toggle bit 0 away with another write to confirm XOR still works.
        do_write('h01, 16'h0001);
        rd('h01, rv); chk("R12 later clear", rv, 16'h0000);

        // R7: watchdog
        do_write('h17, 16'h0000);
        chk("R7 disarmed zero", {15'd0, shutdown_req}, 16'h0000);
        do_write('h0D, 16'h0002);
        do_write('h17, 16'h0005);
        chk("R7 nonzero write", {15'd0, shutdown_req}, 16'h0000);
        do_write('h0D, 16'hFFFD);
        do_write('h17, 16'h0000);
        chk("R7 bit1 clear", {15'd0, shutdown_req}, 16'h0000);
        do_write('h0D, 16'h0002);
        do_write('h17, 16'h0000);
        chk("R7 fires", {15'd0, shutdown_req}, 16'h0001);
        do_write('h0D, 16'h0000);
        repeat (3) @(negedge clk);
        chk("R7 sticky", {15'd0, shutdown_req}, 16'h0001);
        rd('h17, rv); chk("R10 watchdog reads zero", rv, 16'h0000);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule